// File: doc/BRIEF.md
# Constant On-Time Buck Gate Sequencer

This block is the digital timing core of a synchronous step-down controller that has no fixed switching clock. A high-side pulse of programmable length is launched only when the output is below target, the valley current sits under its limit and a minimum off interval has run out. Comparator results arrive already digitised, and the on-time arrives as a cycle count. The block works out the gate enables for both switches, along with the dead times between them.

Between high-side pulses the low-side switch conducts. In skip mode its conduction ends at the first inductor zero-crossing, and it stays off until the next pulse, so the block skips pulses at light load. In forced mode the zero-crossing input is ignored, and the low side is the complement of the high side apart from the dead times. In both modes a negative current-limit flag turns the low side off for as long as it is raised. When the block is shut down or faulted, both enables are held low and no pulse can start.

Top module: `cot_pwm_seq`

## Requirements
- R1: A high-side pulse begins only if `err_low` is 1, `ilim_over` is 0 and the minimum off interval has elapsed, all at the same clock edge. With any of these missing, no pulse begins. From that edge the low side is released and the high side rises one cycle later at the earliest.
- R2: `hs_en` stays high for exactly `ton_cycles` cycles, and a value of 0 counts as 1. Changes of `err_low` during the pulse neither end it early nor restart it.
- R3: After `hs_en` falls, it stays low for at least `MIN_OFF_CYC` cycles. With the demand held and the low side sensed off at once, the low time is exactly `MIN_OFF_CYC`+2 cycles.
- R4: `hs_en` rises only if, at the preceding edge, `ls_en` was 0 and `ls_off_sense` was 1. While the sense input stays 0, the high side waits.
- R5: `ls_en` rises exactly `LS_DLY_CYC` cycles after `hs_en` falls.
- R6: In skip mode (`force_pwm`=0), `zero_cross`=1 drives `ls_en` low at the next edge. It then stays low until the next low-side phase, even after `zero_cross` returns to 0.
- R7: In forced mode (`force_pwm`=1), `zero_cross` has no effect. `ls_en` stays high from its rise until the edge at which the next pulse begins.
- R8: `neg_ilim`=1 drives `ls_en` low at the next edge. Within a low-side phase, `ls_en` returns to 1 one edge after the flag clears.
- R9: While `run`=0 or `fault`=1, both enables are 0 from the next edge onward, and no pulse begins.
- R10: `hs_en` and `ls_en` are never 1 together.
- R11: During reset both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 enables switching, 0 is shutdown |
| fault | input | 1 | Fault active, forces the safe state |
| err_low | input | 1 | Error comparator reports output below target |
| ilim_over | input | 1 | Valley current above the positive limit |
| neg_ilim | input | 1 | Reverse current beyond the negative limit |
| zero_cross | input | 1 | Inductor current has reached zero |
| ls_off_sense | input | 1 | Low-side gate confirmed fully off |
| force_pwm | input | 1 | 1 selects forced mode, 0 selects skip mode |
| ton_cycles | input | TON_W | High-side on-time in clock cycles |
| hs_en | output | 1 | High-side gate enable (registered) |
| ls_en | output | 1 | Low-side gate enable (registered) |

## Verification
Both outputs are registered, so any input change is seen at the first edge after it is driven. A halt, a zero-crossing or a negative-limit flag changes an enable one cycle later. A pulse begins two edges after the last missing start condition is met: one edge releases the low side and the next raises the high side. The on-time, the break delay and the off time are counted from the sampled edges of `hs_en` and `ls_en`. Samples are taken just after each rising edge, and inputs are driven on falling edges. Each measured length is compared with `ton_cycles`, `LS_DLY_CYC` and `MIN_OFF_CYC`+2 across a sweep of on-times in both modes.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_GUARD = 2'd1,
    PH_HIGH  = 2'd2,
    PH_BREAK = 2'd3
  } phase_e;
endpackage

// File: rtl/cot_oneshot.sv
module cot_oneshot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic [W-1:0] remaining
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= value;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign remaining = cnt_q;
endmodule

// File: rtl/cot_lowside.sv
module cot_lowside (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic arm,
  input  logic drop,
  input  logic force_pwm,
  input  logic zero_cross,
  input  logic neg_ilim,
  output logic ls_en
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (halt) begin
      phase_d = 1'b0;
    end else if (drop) begin
      phase_d = 1'b0;
    end else if (arm) begin
      phase_d = force_pwm || !zero_cross;
    end else if (!force_pwm && zero_cross) begin
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      ls_en   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ls_en   <= phase_d && !neg_ilim;
    end
  end

  p_zc_truncate_r6: assert property (@(posedge clk) disable iff (rst)
    (!force_pwm && zero_cross) |=> !ls_en)
    else $error("R6 low side kept on after zero crossing");

  p_neg_limit_r8: assert property (@(posedge clk) disable iff (rst)
    neg_ilim |=> !ls_en)
    else $error("R8 low side kept on under negative limit");

  p_halt_ls_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> !ls_en)
    else $error("R9 low side on while halted");
endmodule

// File: rtl/cot_pwm_seq.sv
module cot_pwm_seq #(
  parameter int TON_W       = 10,
  parameter int MIN_OFF_CYC = 100,
  parameter int LS_DLY_CYC  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fault,
  input  logic             err_low,
  input  logic             ilim_over,
  input  logic             neg_ilim,
  input  logic             zero_cross,
  input  logic             ls_off_sense,
  input  logic             force_pwm,
  input  logic [TON_W-1:0] ton_cycles,
  output logic             hs_en,
  output logic             ls_en
);
  import cot_pkg::*;

  localparam int OFF_W = $clog2(MIN_OFF_CYC + 1);
  localparam int DLY_W = $clog2(LS_DLY_CYC + 1);

  phase_e ph_q;
  logic   hs_en_q;
  logic   halt, start_ok, enter_hi, hi_end, brk_end;
  logic   ton_last, ton_idle, brk_last, brk_idle, off_idle;
  logic [TON_W-1:0] ton_rem, ton_val;
  logic [DLY_W-1:0] brk_rem;
  logic [OFF_W-1:0] off_rem;

  assign halt     = !run || fault;
  assign off_idle = (off_rem == '0);
  assign ton_idle = (ton_rem == '0);
  assign ton_last = (ton_rem == TON_W'(1));
  assign brk_idle = (brk_rem == '0);
  assign brk_last = (brk_rem == DLY_W'(1));
  assign ton_val  = (ton_cycles == '0) ? TON_W'(1) : ton_cycles;

  assign start_ok = (ph_q == PH_WAIT)  && !halt && err_low && !ilim_over && off_idle;
  assign enter_hi = (ph_q == PH_GUARD) && !halt && ls_off_sense && !ls_en;
  assign hi_end   = (ph_q == PH_HIGH)  && !halt && ton_last;
  assign brk_end  = (ph_q == PH_BREAK) && !halt && brk_last;

  cot_oneshot #(.W(TON_W)) u_ton (
    .clk(clk), .rst(rst), .load(enter_hi), .value(ton_val), .remaining(ton_rem)
  );

  cot_oneshot #(.W(DLY_W)) u_brk (
    .clk(clk), .rst(rst), .load(hi_end), .value(DLY_W'(LS_DLY_CYC)), .remaining(brk_rem)
  );

  cot_oneshot #(.W(OFF_W)) u_off (
    .clk(clk), .rst(rst), .load(hi_end), .value(OFF_W'(MIN_OFF_CYC)), .remaining(off_rem)
  );

  cot_lowside u_ls (
    .clk(clk), .rst(rst), .halt(halt), .arm(brk_end), .drop(start_ok),
    .force_pwm(force_pwm), .zero_cross(zero_cross), .neg_ilim(neg_ilim), .ls_en(ls_en)
  );

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      ph_q    <= PH_WAIT;
      hs_en_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_WAIT:  if (start_ok) ph_q <= PH_GUARD;
        PH_GUARD: if (enter_hi) begin
                    ph_q    <= PH_HIGH;
                    hs_en_q <= 1'b1;
                  end
        PH_HIGH:  if (hi_end) begin
                    ph_q    <= PH_BREAK;
                    hs_en_q <= 1'b0;
                  end
        PH_BREAK: if (brk_end) ph_q <= PH_WAIT;
        default:  ph_q <= PH_WAIT;
      endcase
    end
  end

  assign hs_en = hs_en_q;

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(hs_en_q && ls_en))
    else $error("R10 both gates enabled");

  p_dead_adapt_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en_q) |-> ($past(ls_off_sense) && !$past(ls_en)))
    else $error("R4 high side rose before low side sensed off");

  p_min_off_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en_q) |-> off_idle)
    else $error("R3 high side rose inside minimum off time");

  p_ontime_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hs_en_q && !ton_last && !halt) |=> hs_en_q)
    else $error("R2 on-time cut short");

  p_ontime_live_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HIGH) |-> !ton_idle)
    else $error("R2 on-time counter empty during pulse");

  p_break_live_r5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_BREAK) |-> !brk_idle)
    else $error("R5 break counter empty during break");

  p_halt_hs_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> !hs_en_q)
    else $error("R9 high side on while halted");
endmodule

// File: tb/cot_pwm_seq_bench.sv
module cot_pwm_seq_bench;
  localparam int TON_W   = 10;
  localparam int MIN_OFF = 100;
  localparam int LSD     = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, run, fault, err_low, ilim_over, neg_ilim, zero_cross, force_pwm;
  logic sense_block;
  logic ls_off_sense;
  logic [TON_W-1:0] ton_cycles;
  logic hs_en, ls_en;

  assign ls_off_sense = !ls_en && !sense_block;

  cot_pwm_seq #(.TON_W(TON_W), .MIN_OFF_CYC(MIN_OFF), .LS_DLY_CYC(LSD)) u_cot_pwm_seq (
    .clk(clk), .rst(rst), .run(run), .fault(fault), .err_low(err_low),
    .ilim_over(ilim_over), .neg_ilim(neg_ilim), .zero_cross(zero_cross),
    .ls_off_sense(ls_off_sense), .force_pwm(force_pwm), .ton_cycles(ton_cycles),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  int checks = 0, fails = 0;
  int cyc = 0, nrise = 0, nfall = 0, nlsr = 0, ovl = 0;
  int rise_c = 0, fall_c = 0, lsf_c = 0;
  int hi_len = 0, gap = 0, ls_dly = 0, ls_to_hs = 0;
  logic p_hs = 1'b0, p_ls = 1'b0;
  bit done = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (hs_en && !p_hs) begin
      nrise++; gap = cyc - fall_c; ls_to_hs = cyc - lsf_c; rise_c = cyc;
    end
    if (!hs_en && p_hs) begin
      nfall++; hi_len = cyc - rise_c; fall_c = cyc;
    end
    if (ls_en && !p_ls) begin
      nlsr++; ls_dly = cyc - fall_c;
    end
    if (!ls_en && p_ls) lsf_c = cyc;
    if (hs_en && ls_en) ovl++;
    p_hs = hs_en; p_ls = ls_en;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_evt(input int which, input string req);
    int start;
    int cur;
    start = (which == 0) ? nrise : (which == 1) ? nfall : nlsr;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cur = (which == 0) ? nrise : (which == 1) ? nfall : nlsr;
      if (cur != start) return;
    end
    checks++; fails++;
    $display("FAIL %s timeout on event %0d actual=none expected=event", req, which);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n0;
    int tl[9] = '{0, 1, 2, 3, 4, 7, 16, 100, 1023};
    rst = 1; run = 1; fault = 0; err_low = 0; ilim_over = 0; neg_ilim = 0;
    zero_cross = 0; force_pwm = 1; sense_block = 0; ton_cycles = TON_W'(5);
    idle(3);
    chk("R11 hs_en in reset", int'(hs_en), 0);
    chk("R11 ls_en in reset", int'(ls_en), 0);
    rst = 0;
    idle(150);
    chk("R1 no pulse without demand", nrise, 0);

    // on-time, break delay, off time and release order sweep, both modes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 9; k++) begin
        err_low = 0;
        idle(1200);
        force_pwm = m[0];
        ton_cycles = TON_W'(tl[k]);
        err_low = 1;
        wait_evt(0, "R1 sweep start");
        wait_evt(1, "R2 sweep end");
        chk("R2 on-time length", hi_len, (tl[k] == 0) ? 1 : tl[k]);
        wait_evt(2, "R5 sweep ls");
        chk("R5 break delay", ls_dly, LSD);
        wait_evt(0, "R3 sweep second");
        chk("R3 off time", gap, MIN_OFF + 2);
        chk("R4 ls release to hs rise", ls_to_hs, 1);
      end
    end
    err_low = 0;
    idle(1200);

    // R1: current limit blocks start
    ton_cycles = TON_W'(20);
    ilim_over = 1; err_low = 1;
    n0 = nrise;
    idle(300);
    chk("R1 blocked by ilim_over", nrise - n0, 0);
    ilim_over = 0;
    idle(5);
    chk("R1 resumes after limit clears", nrise - n0, 1);
    // R2: demand removed mid-pulse
    err_low = 0;
    wait_evt(1, "R2 pulse end");
    chk("R2 full length after err_low drop", hi_len, 20);
    // R1: demand inside minimum off time
    idle(10);
    err_low = 1; idle(1); err_low = 0;
    n0 = nrise;
    idle(300);
    chk("R1 demand inside off time ignored", nrise - n0, 0);

    // R4: adaptive dead time
    force_pwm = 1;
    sense_block = 1; err_low = 1;
    n0 = nrise;
    idle(30);
    chk("R4 waits for sense", nrise - n0, 0);
    chk("R4 low side released", int'(ls_en), 0);
    sense_block = 0;
    idle(4);
    chk("R4 rises after sense", nrise - n0, 1);
    err_low = 0;
    idle(600);

    // R6: skip mode truncation
    force_pwm = 0; ton_cycles = TON_W'(8); err_low = 1;
    wait_evt(0, "R6 start");
    err_low = 0;
    wait_evt(2, "R6 ls rise");
    idle(5);
    chk("R6 ls on before crossing", int'(ls_en), 1);
    zero_cross = 1; idle(1);
    chk("R6 ls off after crossing", int'(ls_en), 0);
    zero_cross = 0; idle(4);
    chk("R6 ls stays off", int'(ls_en), 0);
    idle(300);

    // R7: forced mode ignores crossing
    force_pwm = 1; err_low = 1;
    wait_evt(0, "R7 start");
    err_low = 0;
    wait_evt(2, "R7 ls rise");
    idle(3);
    zero_cross = 1; idle(3);
    chk("R7 ls on despite crossing", int'(ls_en), 1);
    zero_cross = 0; idle(200);
    chk("R7 ls held as complement", int'(ls_en), 1);

    // R8: negative limit
    neg_ilim = 1; idle(1);
    chk("R8 ls off under neg limit", int'(ls_en), 0);
    idle(3);
    chk("R8 ls held off", int'(ls_en), 0);
    neg_ilim = 0; idle(1);
    chk("R8 ls back on", int'(ls_en), 1);

    // R9: fault and shutdown
    ton_cycles = TON_W'(50); err_low = 1;
    wait_evt(0, "R9 start");
    idle(5);
    fault = 1; idle(1);
    chk("R9 hs off on fault", int'(hs_en), 0);
    chk("R9 ls off on fault", int'(ls_en), 0);
    n0 = nrise;
    idle(300);
    chk("R9 no pulse in fault", nrise - n0, 0);
    chk("R9 ls held off in fault", int'(ls_en), 0);
    fault = 0;
    wait_evt(0, "R9 resume");
    idle(5);
    run = 0; idle(1);
    chk("R9 hs off on shutdown", int'(hs_en), 0);
    n0 = nrise;
    idle(200);
    chk("R9 no pulse in shutdown", nrise - n0, 0);
    run = 1; err_low = 0;
    idle(300);

    chk("R10 overlap cycles", ovl, 0);
    finish_run();
  end
endmodule